// File: doc/BRIEF.md
# Landing-Pad Control-Flow Checker

This block guards forward-edge control flow in a RISC-V style pipeline. It holds one bit of state, the expected-pad flag. A retiring indirect jump sets the flag when landing pads are enabled for the current privilege and the jump's source register is not one of the exempt link or guarded registers. The next fetched instruction must then be a proper landing pad. That means a 4-byte aligned, 32-bit AUIPC whose destination is x0, whose 20-bit label matches bits 31:12 of x7, or whose label is zero, which matches any value.

Any violation produces a one-cycle fault request carrying the software-check cause and the landing-pad trap value. The trap logic downstream acts on that request. A correct landing pad clears the flag. Trap entry, trap return and the storage of the enable bits sit outside this block. It only receives the three enable bits and reports the flag value.

Top module: `lp_cfi_guard`

## Requirements
- R1: A synchronous active-high reset clears the expected-pad flag, the fault pulse, and both code outputs to zero, including when the flag was set before the reset.
- R2: The active enable follows privilege (priv_mode 2'b11 machine, 2'b01 supervisor, 2'b00 user, 2'b10 never enabled). Machine uses m_sec_lpe and supervisor uses m_env_lpe. User uses s_env_lpe when sup_present is 1, and m_env_lpe when sup_present is 0.
- R3: A retiring jump sets the flag on the next clock edge when the enable is active and its rs1 index is not 1, 5 or 7. A jump with rs1 equal to 1, 5 or 7 leaves the flag unchanged.
- R4: While the flag is set, a fetch whose PC bits 1:0 are not 00 faults.
- R5: While the flag is set, a fetch marked compressed faults whatever its bits.
- R6: While the flag is set, a 32-bit fetch faults unless instruction bits 6:0 equal 0010111 and bits 11:7 equal 00000.
- R7: While the flag is set, a well-formed pad faults when its label in bits 31:12 is non-zero and differs from x7 bits 31:12. A zero or matching label clears the flag on the next edge.
- R8: A fault appears as fault_o high for one cycle, in the cycle after the offending fetch. During that cycle fault_cause is 18 and fault_tval is 2. Both codes are 0 whenever fault_o is low.
- R9: While the enable is inactive, fetches are not checked, jumps do not arm, and the flag keeps its value.
- R10: A fault leaves the flag set. Clearing it on the trap is left to the trap logic.
- R11: When a qualifying jump and a fetch arrive in the same cycle, the fetch is judged against the old flag value, and the jump's arming wins over any clear.
- R12: While the flag is clear, no fetch faults, including a landing-pad encoding with a non-matching label.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_mode | input | 2 | Current privilege (11 M, 01 S, 00 U) |
| sup_present | input | 1 | Supervisor mode is implemented |
| m_sec_lpe | input | 1 | Machine-mode landing-pad enable |
| m_env_lpe | input | 1 | Enable for supervisor, or for user when no supervisor exists |
| s_env_lpe | input | 1 | User-mode enable when supervisor exists |
| jmp_retire | input | 1 | An indirect jump retires this cycle |
| jmp_rs1 | input | 5 | Source register index of the retiring jump |
| fetch_valid | input | 1 | A fetched instruction is presented this cycle |
| fetch_pc_lo | input | 2 | PC bits 1:0 of that fetch |
| fetch_insn | input | 32 | Fetched instruction bits |
| fetch_rvc | input | 1 | Fetch is a 16-bit compressed instruction |
| x7_label | input | LABEL_W | Bits 31:12 of register x7 |
| elp_o | output | 1 | Expected-pad flag |
| fault_o | output | 1 | One-cycle landing-pad fault request |
| fault_cause | output | CAUSE_W | Exception cause while faulting (18) |
| fault_tval | output | XLEN | Trap value while faulting (2) |

## Verification
A flag stuck at the wrong value shows up at elp_o on the edge right after the jump or pad that should have changed it. It also shows up one cycle later as a missing or spurious fault_o on the next fetch. An error in encoding, alignment or label inspection shows up as a fault pulse that is wrong in the cycle after the fetch. Whether the flag then stays set or clears exposes whether the pad was judged valid. The bench therefore checks the flag, the pulse and the codes on every step, across each privilege and enable combination and each kind of malformed fetch.

// File: rtl/lp_cfi_pkg.sv
package lp_cfi_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'b00,
        PRIV_S   = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_M   = 2'b11
    } priv_e;

    localparam int unsigned CAUSE_SW_CHECK = 18;
    localparam int unsigned TVAL_LP_FAULT  = 2;
    localparam int unsigned TVAL_SS_FAULT  = 3;   // reserved for return-edge checks

    localparam logic [6:0] OPC_AUIPC = 7'b0010111;

    typedef struct packed {
        logic checked;   // fetch was subject to inspection
        logic fault;     // inspection failed
        logic clear;     // valid pad seen: drop the expectation
    } pad_verdict_t;

    function automatic logic rs1_is_exempt(input logic [4:0] idx);
        return (idx == 5'd1) || (idx == 5'd5) || (idx == 5'd7);
    endfunction

    function automatic logic is_pad_encoding(input logic [31:0] insn);
        return (insn[6:0] == OPC_AUIPC) && (insn[11:7] == 5'd0);
    endfunction

endpackage

// File: rtl/lp_enable_sel.sv
module lp_enable_sel
    import lp_cfi_pkg::*;
(
    input  logic [1:0] priv_mode,
    input  logic       sup_present,
    input  logic       m_sec_lpe,
    input  logic       m_env_lpe,
    input  logic       s_env_lpe,
    output logic       lp_en
);
    always_comb begin
        unique case (priv_e'(priv_mode))
            PRIV_M:  lp_en = m_sec_lpe;
            PRIV_S:  lp_en = m_env_lpe;
            PRIV_U:  lp_en = sup_present ? s_env_lpe : m_env_lpe;
            default: lp_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/lp_arm_decode.sv
module lp_arm_decode
    import lp_cfi_pkg::*;
(
    input  logic       jmp_retire,
    input  logic [4:0] jmp_rs1,
    input  logic       lp_en,
    output logic       arm
);
    always_comb begin
        arm = jmp_retire && lp_en && !rs1_is_exempt(jmp_rs1);
    end
endmodule

// File: rtl/lp_pad_inspect.sv
module lp_pad_inspect
    import lp_cfi_pkg::*;
#(
    parameter int unsigned LABEL_W = 20
) (
    input  logic               elp,
    input  logic               lp_en,
    input  logic               fetch_valid,
    input  logic [1:0]         fetch_pc_lo,
    input  logic [31:0]        fetch_insn,
    input  logic               fetch_rvc,
    input  logic [LABEL_W-1:0] x7_label,
    output pad_verdict_t       verdict
);
    localparam int unsigned LBL_LSB = 32 - LABEL_W;

    logic [LABEL_W-1:0] pad_label;
    logic misaligned, bad_form, label_bad;

    always_comb begin
        pad_label  = fetch_insn[31:LBL_LSB];
        misaligned = (fetch_pc_lo != 2'b00);
        bad_form   = fetch_rvc || !is_pad_encoding(fetch_insn);
        label_bad  = (pad_label != '0) && (pad_label != x7_label);

        verdict.checked = fetch_valid && lp_en && elp;
        verdict.fault   = verdict.checked && (misaligned || bad_form || label_bad);
        verdict.clear   = verdict.checked && !verdict.fault;
    end
endmodule

// File: rtl/lp_cfi_guard.sv
module lp_cfi_guard
    import lp_cfi_pkg::*;
#(
    parameter int unsigned XLEN    = 64,
    parameter int unsigned CAUSE_W = 6,
    parameter int unsigned LABEL_W = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         priv_mode,
    input  logic               sup_present,
    input  logic               m_sec_lpe,
    input  logic               m_env_lpe,
    input  logic               s_env_lpe,
    input  logic               jmp_retire,
    input  logic [4:0]         jmp_rs1,
    input  logic               fetch_valid,
    input  logic [1:0]         fetch_pc_lo,
    input  logic [31:0]        fetch_insn,
    input  logic               fetch_rvc,
    input  logic [LABEL_W-1:0] x7_label,
    output logic               elp_o,
    output logic               fault_o,
    output logic [CAUSE_W-1:0] fault_cause,
    output logic [XLEN-1:0]    fault_tval
);
    localparam logic [CAUSE_W-1:0] CAUSE_VAL = CAUSE_W'(CAUSE_SW_CHECK);
    localparam logic [XLEN-1:0]    TVAL_VAL  = XLEN'(TVAL_LP_FAULT);

    logic         lp_en;
    logic         arm;
    pad_verdict_t verdict;
    logic         elp_q, elp_d;

    lp_enable_sel u_en (
        .priv_mode   (priv_mode),
        .sup_present (sup_present),
        .m_sec_lpe   (m_sec_lpe),
        .m_env_lpe   (m_env_lpe),
        .s_env_lpe   (s_env_lpe),
        .lp_en       (lp_en)
    );

    lp_arm_decode u_arm (
        .jmp_retire (jmp_retire),
        .jmp_rs1    (jmp_rs1),
        .lp_en      (lp_en),
        .arm        (arm)
    );

    lp_pad_inspect #(.LABEL_W(LABEL_W)) u_pad (
        .elp         (elp_q),
        .lp_en       (lp_en),
        .fetch_valid (fetch_valid),
        .fetch_pc_lo (fetch_pc_lo),
        .fetch_insn  (fetch_insn),
        .fetch_rvc   (fetch_rvc),
        .x7_label    (x7_label),
        .verdict     (verdict)
    );

    // Arming beats clearing; a fault leaves the flag alone.
    always_comb begin
        if (arm)                elp_d = 1'b1;
        else if (verdict.clear) elp_d = 1'b0;
        else                    elp_d = elp_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            elp_q       <= 1'b0;
            fault_o     <= 1'b0;
            fault_cause <= '0;
            fault_tval  <= '0;
        end else begin
            elp_q       <= elp_d;
            fault_o     <= verdict.fault;
            fault_cause <= verdict.fault ? CAUSE_VAL : '0;
            fault_tval  <= verdict.fault ? TVAL_VAL  : '0;
        end
    end

    assign elp_o = elp_q;

endmodule

// File: rtl/lp_cfi_guard_chk.sv
module lp_cfi_guard_chk
    import lp_cfi_pkg::*;
#(
    parameter int unsigned XLEN    = 64,
    parameter int unsigned CAUSE_W = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               jmp_retire,
    input logic [4:0]         jmp_rs1,
    input logic               lp_en,
    input logic               elp_o,
    input logic               fault_o,
    input logic [CAUSE_W-1:0] fault_cause,
    input logic [XLEN-1:0]    fault_tval
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!elp_o && !fault_o && fault_cause == '0 && fault_tval == '0));

    a_r3_jump_arms: assert property (@(posedge clk) disable iff (rst)
        (jmp_retire && lp_en && !rs1_is_exempt(jmp_rs1)) |=> elp_o);

    a_r8_fault_codes: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> (fault_cause == CAUSE_W'(CAUSE_SW_CHECK) && fault_tval == XLEN'(TVAL_LP_FAULT)));

    a_r8_quiet_codes: assert property (@(posedge clk) disable iff (rst)
        !fault_o |-> (fault_cause == '0 && fault_tval == '0));

    a_r9_disabled_holds: assert property (@(posedge clk) disable iff (rst)
        !lp_en |=> (elp_o == $past(elp_o)));

    a_r10_fault_keeps_flag: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> elp_o);

    a_r12_no_fault_unarmed: assert property (@(posedge clk) disable iff (rst)
        (!elp_o || !lp_en) |=> !fault_o);
endmodule

bind lp_cfi_guard lp_cfi_guard_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .jmp_retire  (jmp_retire),
    .jmp_rs1     (jmp_rs1),
    .lp_en       (lp_en),
    .elp_o       (elp_o),
    .fault_o     (fault_o),
    .fault_cause (fault_cause),
    .fault_tval  (fault_tval)
);

// File: tb/tb_lp_cfi_guard.sv
module tb_lp_cfi_guard;
    localparam int XLEN = 64;
    localparam int CW   = 6;
    localparam int LW   = 20;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    priv_mode;
    logic          sup_present, m_sec_lpe, m_env_lpe, s_env_lpe;
    logic          jmp_retire;
    logic [4:0]    jmp_rs1;
    logic          fetch_valid;
    logic [1:0]    fetch_pc_lo;
    logic [31:0]   fetch_insn;
    logic          fetch_rvc;
    logic [LW-1:0] x7_label;
    logic          elp_o, fault_o;
    logic [CW-1:0] fault_cause;
    logic [XLEN-1:0] fault_tval;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    lp_cfi_guard #(.XLEN(XLEN), .CAUSE_W(CW), .LABEL_W(LW)) dut (
        .clk(clk), .rst(rst), .priv_mode(priv_mode), .sup_present(sup_present),
        .m_sec_lpe(m_sec_lpe), .m_env_lpe(m_env_lpe), .s_env_lpe(s_env_lpe),
        .jmp_retire(jmp_retire), .jmp_rs1(jmp_rs1), .fetch_valid(fetch_valid),
        .fetch_pc_lo(fetch_pc_lo), .fetch_insn(fetch_insn), .fetch_rvc(fetch_rvc),
        .x7_label(x7_label), .elp_o(elp_o), .fault_o(fault_o),
        .fault_cause(fault_cause), .fault_tval(fault_tval)
    );

    function automatic logic [31:0] pad(input logic [19:0] lbl);
        return {lbl, 5'd0, 7'b0010111};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock: strobes are held over one rising edge, sampled 1 ns later.
    task automatic tick();
        @(posedge clk);
        #1;
        jmp_retire  = 1'b0;
        fetch_valid = 1'b0;
        fetch_rvc   = 1'b0;
        fetch_pc_lo = 2'b00;
    endtask

    task automatic jump(input logic [4:0] rs1);
        jmp_retire = 1'b1; jmp_rs1 = rs1; tick();
    endtask

    task automatic fetch(input logic [1:0] pclo, input logic [31:0] insn, input logic rvc);
        fetch_valid = 1'b1; fetch_pc_lo = pclo; fetch_insn = insn; fetch_rvc = rvc; tick();
    endtask

    task automatic set_mode(input logic [1:0] p, input logic sp,
                            input logic ms, input logic me, input logic se);
        priv_mode = p; sup_present = sp; m_sec_lpe = ms; m_env_lpe = me; s_env_lpe = se;
    endtask

    task automatic clear_flag();
        fetch(2'b00, pad(20'h0), 1'b0);
    endtask

    task automatic t_reset();
        rst = 1'b1; tick(); tick(); rst = 1'b0; tick();
        chk("R1 elp after reset", elp_o, 0);
        chk("R1 fault after reset", fault_o, 0);
        chk("R1 cause after reset", fault_cause, 0);
        chk("R1 tval after reset", fault_tval, 0);
        jump(5'd10);
        rst = 1'b1; tick(); rst = 1'b0;
        chk("R1 reset clears set flag", elp_o, 0);
    endtask

    task automatic t_enable_select();
        set_mode(2'b11, 1, 0, 1, 1); jump(5'd10);
        chk("R2 M ignores env bits", elp_o, 0);
        set_mode(2'b11, 1, 1, 0, 0); jump(5'd10);
        chk("R2 M uses sec bit", elp_o, 1);
        clear_flag();
        set_mode(2'b01, 1, 1, 0, 1); jump(5'd10);
        chk("R2 S ignores sec and s-env", elp_o, 0);
        set_mode(2'b01, 1, 0, 1, 0); jump(5'd10);
        chk("R2 S uses m-env", elp_o, 1);
        clear_flag();
        set_mode(2'b00, 1, 1, 1, 0); jump(5'd10);
        chk("R2 U with sup uses s-env (off)", elp_o, 0);
        set_mode(2'b00, 1, 0, 0, 1); jump(5'd10);
        chk("R2 U with sup uses s-env (on)", elp_o, 1);
        clear_flag();
        set_mode(2'b00, 0, 0, 1, 0); jump(5'd10);
        chk("R2 U without sup uses m-env", elp_o, 1);
        clear_flag();
        set_mode(2'b10, 1, 1, 1, 1); jump(5'd10);
        chk("R2 reserved priv never enabled", elp_o, 0);
        set_mode(2'b11, 1, 1, 0, 0);
    endtask

    task automatic t_arm_filter();
        jump(5'd1);  chk("R3 rs1=x1 exempt", elp_o, 0);
        jump(5'd5);  chk("R3 rs1=x5 exempt", elp_o, 0);
        jump(5'd7);  chk("R3 rs1=x7 exempt", elp_o, 0);
        jump(5'd6);  chk("R3 rs1=x6 arms", elp_o, 1);
        clear_flag(); chk("R7 zero label clears", elp_o, 0);
        jump(5'd0);  chk("R3 rs1=x0 arms", elp_o, 1);
        clear_flag();
    endtask

    task automatic t_misaligned();
        jump(5'd10);
        fetch(2'b10, pad(20'h0), 1'b0);
        chk("R4 misaligned faults", fault_o, 1);
        chk("R8 cause 18", fault_cause, 18);
        chk("R8 tval 2", fault_tval, 2);
        chk("R10 flag kept after fault", elp_o, 1);
        tick();
        chk("R8 fault is one cycle", fault_o, 0);
        chk("R8 codes zero after pulse", fault_tval, 0);
        fetch(2'b01, pad(20'h0), 1'b0);
        chk("R4 pc lo 01 faults", fault_o, 1);
        clear_flag();
        chk("R7 aligned pad clears after fault", elp_o, 0);
    endtask

    task automatic t_compressed();
        jump(5'd11);
        fetch(2'b00, pad(20'h0), 1'b1);
        chk("R5 compressed faults", fault_o, 1);
        chk("R10 flag kept", elp_o, 1);
        clear_flag();
    endtask

    task automatic t_bad_encoding();
        jump(5'd12);
        fetch(2'b00, 32'h0000_0013, 1'b0);
        chk("R6 wrong opcode faults", fault_o, 1);
        fetch(2'b00, {20'h0, 5'd3, 7'b0010111}, 1'b0);
        chk("R6 auipc rd!=0 faults", fault_o, 1);
        chk("R6 flag still set", elp_o, 1);
        clear_flag();
        chk("R6 good pad no fault", fault_o, 0);
    endtask

    task automatic t_label();
        x7_label = 20'hABCDE;
        jump(5'd10);
        fetch(2'b00, pad(20'h12345), 1'b0);
        chk("R7 mismatched label faults", fault_o, 1);
        chk("R7 flag kept on mismatch", elp_o, 1);
        fetch(2'b00, pad(20'hABCDE), 1'b0);
        chk("R7 matching label no fault", fault_o, 0);
        chk("R7 matching label clears", elp_o, 0);
        fetch(2'b00, pad(20'h12345), 1'b0);
        chk("R12 unarmed pad mismatch ignored", fault_o, 0);
        fetch(2'b11, 32'h0, 1'b1);
        chk("R12 unarmed junk ignored", fault_o, 0);
    endtask

    task automatic t_disabled();
        jump(5'd10);
        m_sec_lpe = 1'b0;
        fetch(2'b00, 32'h0000_0013, 1'b0);
        chk("R9 no check when disabled", fault_o, 0);
        chk("R9 flag held when disabled", elp_o, 1);
        fetch(2'b00, pad(20'h0), 1'b0);
        chk("R9 pad does not clear when disabled", elp_o, 1);
        m_sec_lpe = 1'b1;
        clear_flag();
        m_sec_lpe = 1'b0; jump(5'd10);
        chk("R9 jump does not arm when disabled", elp_o, 0);
        m_sec_lpe = 1'b1;
    endtask

    task automatic t_priority();
        x7_label = 20'h00001;
        jump(5'd10);
        jmp_retire = 1'b1; jmp_rs1 = 5'd10;
        fetch(2'b00, pad(20'h00001), 1'b0);
        chk("R11 arm beats clear", elp_o, 1);
        chk("R11 valid pad no fault", fault_o, 0);
        jmp_retire = 1'b1; jmp_rs1 = 5'd10;
        fetch(2'b00, 32'h0000_0013, 1'b0);
        chk("R11 old flag still judged", fault_o, 1);
        chk("R11 flag set", elp_o, 1);
        jmp_retire = 1'b1; jmp_rs1 = 5'd5;
        fetch(2'b00, pad(20'h0), 1'b0);
        chk("R11 exempt jump lets pad clear", elp_o, 0);
        jmp_retire = 1'b1; jmp_rs1 = 5'd9;
        fetch(2'b00, 32'h0000_0013, 1'b0);
        chk("R11 unarmed fetch with jump no fault", fault_o, 0);
        chk("R11 jump arms", elp_o, 1);
        clear_flag();
    endtask

    initial begin
        rst = 1'b1; jmp_retire = 1'b0; jmp_rs1 = '0; fetch_valid = 1'b0;
        fetch_pc_lo = '0; fetch_insn = '0; fetch_rvc = 1'b0; x7_label = '0;
        set_mode(2'b11, 1, 1, 0, 0);
        t_reset();
        t_enable_select();
        t_arm_filter();
        t_misaligned();
        t_compressed();
        t_bad_encoding();
        t_label();
        t_disabled();
        t_priority();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule